// File: doc/BRIEF.md
# Instruction Fetch Loop Buffer

This block sits between the instruction fetch stages and the decoder. Most of the time it is transparent: each fetched word goes straight to the decoder in the same cycle. A start command arms it with two values, the number of instructions in a loop body and how many times the body runs.

On the first pass, the body flows through to the decoder unchanged and is recorded into a small register store at the same time. For each later pass, the block feeds the decoder from the store and raises a lock request that stalls the upstream fetch stages. After the final replayed word, it drops the lock request and returns to pass-through. The front end of the fetch unit drives the start command, and the start cycle's own instruction does not belong to the body.

The store depth, the instruction width and the iteration counter width are parameters. While the block is armed, a global pipeline lock freezes its progress. While it is idle, that lock has no effect on it.

Top module: `fetch_loop_buffer`

## Requirements
- R1: After reset the block is idle: `lock_req_o` is low and the decoder outputs follow the fetch inputs.
- R2: While idle, `dec_valid_o` equals `fetch_valid_i` and `dec_instr_o` equals `fetch_instr_i` in the same cycle, whatever the value of `glock_i`.
- R3: A start with `body_len_i` from 1 to DEPTH and `iter_cnt_i` of 1 or more is accepted. The next `body_len_i` fetch words that arrive with `fetch_valid_i` high and `glock_i` low are recorded in order. During this capture they pass to the decoder unchanged, with `lock_req_o` low.
- R4: When `iter_cnt_i` was 2 or more, `lock_req_o` goes high in the cycle after the last body word is captured. The block then drives the recorded body in order with `dec_valid_o` high, wrapping after the last word, for `iter_cnt_i`-1 passes. The fetch inputs are ignored during this time.
- R5: In the cycle after the last replayed word, `lock_req_o` is low and the decoder outputs follow the fetch inputs again.
- R6: A start with `body_len_i` of 0, `body_len_i` above DEPTH, or `iter_cnt_i` of 0 is ignored. The block stays in pass-through and `lock_req_o` never rises.
- R7: A start with `iter_cnt_i` of 1 captures the body but never replays it, and `lock_req_o` stays low.
- R8: While armed, a cycle with `glock_i` high does not advance the block. During replay the same word is held at the output. During capture the presented word is not recorded.
- R9: A start pulse that arrives while the block is capturing or replaying is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle loop start command |
| body_len_i | input | LEN_W | Loop body length in instructions |
| iter_cnt_i | input | ITER_W | Total number of passes over the body |
| fetch_valid_i | input | 1 | Fetch stage word valid |
| fetch_instr_i | input | INSTR_W | Fetch stage instruction word |
| glock_i | input | 1 | Global pipeline lock |
| dec_valid_o | output | 1 | Instruction valid toward the decoder |
| dec_instr_o | output | INSTR_W | Instruction toward the decoder |
| lock_req_o | output | 1 | Request to stall the upstream fetch stages |

## Verification
The main walk runs a three-word body over three passes. During capture it includes a bubble and a locked cycle, during replay it includes a locked cycle, and it sends a stray start partway through replay. This separates a correct design from one that records bubbles or locked words, one that advances under lock, one that restarts on a second start, and one that ends a pass early. Separate patterns cover a one-word body, which shows wrap handling at the smallest length, and a full-depth body, which shows the pointer reaching the last entry. Single-pass starts and each kind of rejected start are each followed by a long run of fetch words, so that a wrongly accepted start would show up as a lock request.

// File: rtl/flb_pkg.sv
package flb_pkg;

  typedef enum logic [1:0] {
    LB_IDLE    = 2'd0,
    LB_CAPTURE = 2'd1,
    LB_REPLAY  = 2'd2
  } lb_state_e;

endpackage

// File: rtl/flb_store.sv
module flb_store #(
  parameter int INSTR_W = 32,
  parameter int DEPTH   = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   addr,
  input  logic [INSTR_W-1:0] wdata,
  output logic [INSTR_W-1:0] rdata
);

  logic [INSTR_W-1:0] mem [DEPTH];

  // one clock-enabled register row per entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    logic row_en;
    assign row_en = wr_en && (addr == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (row_en) mem[e] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/flb_ctrl.sv
module flb_ctrl
  import flb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ITER_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  body_len_i,
  input  logic [ITER_W-1:0] iter_cnt_i,
  input  logic              fetch_valid_i,
  input  logic              glock_i,
  output lb_state_e         state_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  ptr_o
);

  lb_state_e         state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ITER_W-1:0] rem_q, rem_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              state_en, len_en, rem_en, ptr_en;

  logic args_ok, accept, at_last, cap_step, rep_step;

  assign args_ok  = (body_len_i != '0) && (body_len_i <= LEN_W'(DEPTH)) &&
                    (iter_cnt_i != '0);
  assign accept   = (state_q == LB_IDLE) && start_i && args_ok;
  assign at_last  = (LEN_W'(ptr_q) == (len_q - LEN_W'(1)));
  assign cap_step = (state_q == LB_CAPTURE) && fetch_valid_i && !glock_i;
  assign rep_step = (state_q == LB_REPLAY) && !glock_i;

  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    rem_d    = rem_q;
    ptr_d    = ptr_q;
    state_en = 1'b0;
    len_en   = 1'b0;
    rem_en   = 1'b0;
    ptr_en   = 1'b0;
    unique case (state_q)
      LB_IDLE: begin
        if (accept) begin
          state_d  = LB_CAPTURE;
          len_d    = body_len_i;
          rem_d    = iter_cnt_i - ITER_W'(1);
          ptr_d    = '0;
          state_en = 1'b1;
          len_en   = 1'b1;
          rem_en   = 1'b1;
          ptr_en   = 1'b1;
        end
      end
      LB_CAPTURE: begin
        if (cap_step) begin
          ptr_en = 1'b1;
          if (at_last) begin
            ptr_d    = '0;
            state_en = 1'b1;
            state_d  = (rem_q == '0) ? LB_IDLE : LB_REPLAY;
          end else begin
            ptr_d = ptr_q + PTR_W'(1);
          end
        end
      end
      LB_REPLAY: begin
        if (rep_step) begin
          ptr_en = 1'b1;
          if (at_last) begin
            ptr_d  = '0;
            rem_en = 1'b1;
            rem_d  = rem_q - ITER_W'(1);
            if (rem_q == ITER_W'(1)) begin
              state_en = 1'b1;
              state_d  = LB_IDLE;
            end
          end else begin
            ptr_d = ptr_q + PTR_W'(1);
          end
        end
      end
      default: begin
        state_d  = LB_IDLE;
        state_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LB_IDLE;
      len_q   <= '0;
      rem_q   <= '0;
      ptr_q   <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (len_en)   len_q   <= len_d;
      if (rem_en)   rem_q   <= rem_d;
      if (ptr_en)   ptr_q   <= ptr_d;
    end
  end

  assign state_o = state_q;
  assign wr_en_o = cap_step;
  assign ptr_o   = ptr_q;

endmodule

// File: rtl/fetch_loop_buffer.sv
module fetch_loop_buffer
  import flb_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int DEPTH   = 16,
  parameter int ITER_W  = 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   body_len_i,
  input  logic [ITER_W-1:0]  iter_cnt_i,
  input  logic               fetch_valid_i,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  input  logic               glock_i,
  output logic               dec_valid_o,
  output logic [INSTR_W-1:0] dec_instr_o,
  output logic               lock_req_o
);

  lb_state_e          loop_state;
  logic               buf_wr;
  logic [PTR_W-1:0]   buf_ptr;
  logic [INSTR_W-1:0] buf_word;

  flb_ctrl #(.DEPTH(DEPTH), .ITER_W(ITER_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .body_len_i   (body_len_i),
    .iter_cnt_i   (iter_cnt_i),
    .fetch_valid_i(fetch_valid_i),
    .glock_i      (glock_i),
    .state_o      (loop_state),
    .wr_en_o      (buf_wr),
    .ptr_o        (buf_ptr)
  );

  flb_store #(.INSTR_W(INSTR_W), .DEPTH(DEPTH)) u_store (
    .clk  (clk),
    .wr_en(buf_wr),
    .addr (buf_ptr),
    .wdata(fetch_instr_i),
    .rdata(buf_word)
  );

  logic replaying;
  assign replaying   = (loop_state == LB_REPLAY);
  assign lock_req_o  = replaying;
  assign dec_valid_o = replaying ? 1'b1 : fetch_valid_i;
  assign dec_instr_o = replaying ? buf_word : fetch_instr_i;

endmodule

// File: rtl/flb_checker.sv
module flb_checker
  import flb_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int LEN_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [LEN_W-1:0]   body_len_i,
  input logic               fetch_valid_i,
  input logic [INSTR_W-1:0] fetch_instr_i,
  input logic               glock_i,
  input logic               dec_valid_o,
  input logic [INSTR_W-1:0] dec_instr_o,
  input logic               lock_req_o,
  input lb_state_e          loop_state
);

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_req_o |-> (dec_valid_o == fetch_valid_i) && (dec_instr_o == fetch_instr_i));

  a_r4_replay_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req_o |-> dec_valid_o);

  a_r8_lock_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req_o && glock_i) |=> (lock_req_o && $stable(dec_instr_o)));

  a_r6_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_state == LB_IDLE && start_i && body_len_i == '0) |=> (loop_state == LB_IDLE));

  a_r4_lock_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_req_o) |-> ($past(loop_state) == LB_CAPTURE));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_state == LB_REPLAY && start_i && glock_i) |=> (loop_state == LB_REPLAY));

endmodule

bind fetch_loop_buffer flb_checker #(.INSTR_W(INSTR_W), .LEN_W(LEN_W)) u_flb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .body_len_i   (body_len_i),
  .fetch_valid_i(fetch_valid_i),
  .fetch_instr_i(fetch_instr_i),
  .glock_i      (glock_i),
  .dec_valid_o  (dec_valid_o),
  .dec_instr_o  (dec_instr_o),
  .lock_req_o   (lock_req_o),
  .loop_state   (loop_state)
);

// File: tb/fetch_loop_buffer_test.sv
module fetch_loop_buffer_test;

  localparam int INSTR_W = 32;
  localparam int DEPTH   = 16;
  localparam int ITER_W  = 8;
  localparam int LEN_W   = $clog2(DEPTH + 1);

  logic               clk;
  logic               rst_n;
  logic               start_i;
  logic [LEN_W-1:0]   body_len_i;
  logic [ITER_W-1:0]  iter_cnt_i;
  logic               fetch_valid_i;
  logic [INSTR_W-1:0] fetch_instr_i;
  logic               glock_i;
  logic               dec_valid_o;
  logic [INSTR_W-1:0] dec_instr_o;
  logic               lock_req_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  fetch_loop_buffer #(.INSTR_W(INSTR_W), .DEPTH(DEPTH), .ITER_W(ITER_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .body_len_i(body_len_i),
    .iter_cnt_i(iter_cnt_i), .fetch_valid_i(fetch_valid_i),
    .fetch_instr_i(fetch_instr_i), .glock_i(glock_i), .dec_valid_o(dec_valid_o),
    .dec_instr_o(dec_instr_o), .lock_req_o(lock_req_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic              st;
    logic [LEN_W-1:0]  len;
    logic [ITER_W-1:0] it;
    logic              fv;
    logic [31:0]       fi;
    logic              gl;
    logic              ev;
    logic [31:0]       ei;
    logic              el;
  } vec_t;

  // body of 3 words, 3 passes; bubble and lock in capture, lock and stray start in replay
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0A0, 1'b1, 1'b1, 32'h0A0, 1'b0}, // R2 idle, lock ignored
    '{1'b1, 5'd3, 8'd3, 1'b1, 32'h100, 1'b0, 1'b1, 32'h100, 1'b0}, // R3 start cycle
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h011, 1'b0, 1'b1, 32'h011, 1'b0}, // R3 capture 0
    '{1'b0, 5'd0, 8'd0, 1'b0, 32'h055, 1'b0, 1'b0, 32'h055, 1'b0}, // R3 bubble
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0BB, 1'b1, 1'b1, 32'h0BB, 1'b0}, // R8 locked, not kept
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h012, 1'b0, 1'b1, 32'h012, 1'b0}, // R3 capture 1
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h013, 1'b0, 1'b1, 32'h013, 1'b0}, // R3 capture 2
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0EE, 1'b0, 1'b1, 32'h011, 1'b1}, // R4 replay
    '{1'b1, 5'd5, 8'd9, 1'b1, 32'h0EE, 1'b0, 1'b1, 32'h012, 1'b1}, // R9 stray start
    '{1'b0, 5'd0, 8'd0, 1'b0, 32'h0EE, 1'b1, 1'b1, 32'h013, 1'b1}, // R8 frozen
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0EE, 1'b0, 1'b1, 32'h013, 1'b1}, // R8 resumes
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0EE, 1'b0, 1'b1, 32'h011, 1'b1}, // R4 wrap
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0EE, 1'b0, 1'b1, 32'h012, 1'b1}, // R4
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h0EE, 1'b0, 1'b1, 32'h013, 1'b1}, // R4 last
    '{1'b0, 5'd0, 8'd0, 1'b1, 32'h014, 1'b0, 1'b1, 32'h014, 1'b0}  // R5 release
  };

  task automatic drive(input logic st, input logic [LEN_W-1:0] len,
                       input logic [ITER_W-1:0] it, input logic fv,
                       input logic [31:0] fi, input logic gl);
    @(negedge clk);
    start_i = st; body_len_i = len; iter_cnt_i = it;
    fetch_valid_i = fv; fetch_instr_i = fi; glock_i = gl;
    #3;
  endtask

  task automatic check(input string req, input logic ev, input logic [31:0] ei,
                       input logic el);
    checks++;
    if (dec_valid_o !== ev || dec_instr_o !== ei || lock_req_o !== el) begin
      failures++;
      $display("FAIL %s: got valid=%b instr=%h lock=%b, expected valid=%b instr=%h lock=%b",
               req, dec_valid_o, dec_instr_o, lock_req_o, ev, ei, el);
    end
  endtask

  // feed n words after a start and require that no lock ever rises
  task automatic run_no_lock(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      drive(1'b0, '0, '0, 1'b1, 32'h300 + k, 1'b0);
      check(req, 1'b1, 32'h300 + k, 1'b0);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; body_len_i = '0; iter_cnt_i = '0;
    fetch_valid_i = 1'b0; fetch_instr_i = '0; glock_i = 1'b0;
    #23;
    check("R1 reset", 1'b0, 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, '0, '0, 1'b1, 32'h777, 1'b0);
    check("R1 after reset", 1'b1, 32'h777, 1'b0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].st, VEC[v].len, VEC[v].it, VEC[v].fv, VEC[v].fi, VEC[v].gl);
      check($sformatf("R2-R9 vector %0d", v), VEC[v].ev, VEC[v].ei, VEC[v].el);
    end

    // R6: zero length, oversize length, zero iterations
    drive(1'b1, 5'd0, 8'd4, 1'b1, 32'h200, 1'b0);
    check("R6 zero len", 1'b1, 32'h200, 1'b0);
    run_no_lock("R6 zero len", DEPTH + 2);
    drive(1'b1, 5'(DEPTH + 1), 8'd4, 1'b1, 32'h201, 1'b0);
    check("R6 oversize len", 1'b1, 32'h201, 1'b0);
    run_no_lock("R6 oversize len", DEPTH + 2);
    drive(1'b1, 5'd2, 8'd0, 1'b1, 32'h202, 1'b0);
    check("R6 zero iter", 1'b1, 32'h202, 1'b0);
    run_no_lock("R6 zero iter", DEPTH + 2);

    // R7: single pass never locks; a later start is accepted again
    drive(1'b1, 5'd4, 8'd1, 1'b1, 32'h203, 1'b0);
    check("R7 start", 1'b1, 32'h203, 1'b0);
    run_no_lock("R7 single pass", 8);

    // R4: one-word body, four passes
    drive(1'b1, 5'd1, 8'd4, 1'b1, 32'h204, 1'b0);
    check("R3 len1 start", 1'b1, 32'h204, 1'b0);
    drive(1'b0, '0, '0, 1'b1, 32'h0C1, 1'b0);
    check("R3 len1 capture", 1'b1, 32'h0C1, 1'b0);
    for (int p = 0; p < 3; p++) begin
      drive(1'b0, '0, '0, 1'b0, 32'h0, 1'b0);
      check("R4 len1 replay", 1'b1, 32'h0C1, 1'b1);
    end
    drive(1'b0, '0, '0, 1'b1, 32'h0C2, 1'b0);
    check("R5 len1 release", 1'b1, 32'h0C2, 1'b0);

    // R4: full-depth body, two passes
    drive(1'b1, 5'(DEPTH), 8'd2, 1'b1, 32'h205, 1'b0);
    check("R3 full start", 1'b1, 32'h205, 1'b0);
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b0, '0, '0, 1'b1, 32'h900 + k, 1'b0);
      check("R3 full capture", 1'b1, 32'h900 + k, 1'b0);
    end
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b0, '0, '0, 1'b1, 32'hDEAD, 1'b0);
      check("R4 full replay", 1'b1, 32'h900 + k, 1'b1);
    end
    drive(1'b0, '0, '0, 1'b1, 32'h0C3, 1'b1);
    check("R5 full release", 1'b1, 32'h0C3, 1'b0);

    finish_run();
  end

endmodule